// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches the running calendar time and raises an alarm when it reaches a programmed minute, hour, day of month and weekday. Four alarm registers hold the target values. Each register also has its own disable bit, which leaves that field out of the comparison. The comparison runs only on the strobe that marks a minute update. The result therefore fires once per matching minute and does not repeat on every clock cycle while the match lasts.

A match sets a sticky alarm flag. Software clears the flag by writing to the control register. When the alarm interrupt enable is set, the flag pulls a shared active-low interrupt line low. That line is also pulled low by an external periodic timer request. The time fields come from a separate clock-keeping block, and register access arrives from a bus front end. Neither of those is part of this design.

Top module: `alm_cmp`

## Requirements
- R1: After reset, the control register reads 0x00, each of the four alarm registers reads 0x80 (field disabled), the flag output is 0 and `int_n` is high.
- R2: The register map is as follows. Address 0 is control, with bit 0 the alarm interrupt enable and bit 1 the alarm flag. Address 1 is the minute alarm, address 2 the hour alarm, address 3 the day-of-month alarm and address 4 the weekday alarm. Each alarm register stores all 8 written bits and reads them back. Addresses 5 to 7 read 0x00.
- R3: In each alarm register, bits 6:0 hold the BCD target and bit 7 is the disable bit. On a cycle with `minute_step` high, the flag is set on the next edge when at least one field is enabled and every enabled field equals its zero-extended current time value. Hours are 24-hour BCD.
- R4: A field whose bit 7 is 1 has no effect on the match. Its current time value may differ from its target and the alarm still fires.
- R5: The flag is never set on a cycle where `minute_step` is low, even when the current time matches.
- R6: The flag stays set until a control write with bit 1 equal to 0. A control write with bit 1 equal to 1 leaves the flag unchanged. If a clearing write and a setting match fall on the same cycle, the flag ends up set.
- R7: `int_n` is low exactly when `timer_irq` is high, or when both the flag and the interrupt enable are 1. The output is combinational from these signals.
- R8: When all four disable bits are 1, the flag is never set.
- R9: With the interrupt enable at 0, the flag still sets on a match, but `int_n` stays high unless `timer_irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, 24-hour BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday code |
| minute_step | input | 1 | One-cycle strobe on each minute update |
| timer_irq | input | 1 | Periodic timer interrupt request, active high |
| int_n | output | 1 | Shared interrupt line, active low |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The assertions assume three things about the inputs. `minute_step` is a single-cycle pulse. The time fields are stable in the cycle it is high. Register writes are synchronous single-cycle strobes. The stimulus drives every input at the falling edge and raises the strobe for one cycle at a time. It draws the time values and alarm targets from small BCD sets so that matches, mismatches, disabled fields and clear-versus-match collisions all occur often.

// File: rtl/alm_pkg.sv
package alm_pkg;
   localparam int DATA_W      = 8;
   localparam int NUM_FIELDS  = 4;
   localparam int AE_BIT      = 7;
   localparam int CTRL_AIE    = 0;
   localparam int CTRL_AF     = 1;
   localparam logic [DATA_W-1:0] ALM_RESET = 8'h80;

   typedef enum logic [2:0] {
      A_CTRL = 3'd0,
      A_MIN  = 3'd1,
      A_HOUR = 3'd2,
      A_DAY  = 3'd3,
      A_WDAY = 3'd4
   } alm_addr_e;
endpackage

// File: rtl/alm_field_match.sv
module alm_field_match #(
   parameter int VAL_W = 7
) (
   input  logic [VAL_W:0]   reg_q,
   input  logic [VAL_W-1:0] cur,
   output logic             en,
   output logic             hit
);
   always_comb begin
      en  = ~reg_q[VAL_W];
      hit = (reg_q[VAL_W-1:0] == cur);
   end
endmodule

// File: rtl/alm_regfile.sv
module alm_regfile
   import alm_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [NUM_FIELDS-1:0][DATA_W-1:0] regs_q
);
   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           regs_q[i] <= ALM_RESET;
         else if (wr_en && wr_addr == MY_ADDR) regs_q[i] <= wr_data;
      end
   end
endmodule

// File: rtl/alm_flag.sv
module alm_flag
   import alm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] ctrl_wdata,
   input  logic              step,
   input  logic              any_en,
   input  logic              all_hit,
   output logic              af_q,
   output logic              aie_q
);
   logic fire, clr;

   always_comb begin
      fire = step && any_en && all_hit;
      clr  = ctrl_wr && !ctrl_wdata[CTRL_AF];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         af_q  <= 1'b0;
         aie_q <= 1'b0;
      end else begin
         if (fire)     af_q <= 1'b1;
         else if (clr) af_q <= 1'b0;
         if (ctrl_wr)  aie_q <= ctrl_wdata[CTRL_AIE];
      end
   end

   a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      step && any_en && all_hit |=> af_q);
   a_r5_no_set_without_step: assert property (@(posedge clk) disable iff (!rst_n)
      !af_q && !step |=> !af_q);
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      af_q && !(ctrl_wr && !ctrl_wdata[CTRL_AF]) |=> af_q);
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      af_q && ctrl_wr && !ctrl_wdata[CTRL_AF] && !step |=> !af_q);
   a_r8_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      !af_q && !any_en |=> !af_q);
endmodule

// File: rtl/alm_cmp.sv
module alm_cmp
   import alm_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int VAL_W  = 7,
   parameter int MIN_W  = 7,
   parameter int HOUR_W = 6,
   parameter int DAY_W  = 6,
   parameter int WDAY_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic [MIN_W-1:0]  cur_min,
   input  logic [HOUR_W-1:0] cur_hour,
   input  logic [DAY_W-1:0]  cur_day,
   input  logic [WDAY_W-1:0] cur_wday,
   input  logic              minute_step,
   input  logic              timer_irq,
   output logic              int_n,
   output logic              alarm_flag
);
   localparam int NUM_ADDR = 1 << ADDR_W;

   if (VAL_W + 1 != DATA_W) begin : g_bad_val
      $error("alarm value plus disable bit must fill one data byte");
   end
   if (MIN_W > VAL_W || HOUR_W > VAL_W || DAY_W > VAL_W || WDAY_W > VAL_W) begin : g_bad_cur
      $error("time field wider than alarm value");
   end
   if (NUM_ADDR < NUM_FIELDS + 1) begin : g_bad_addr
      $error("address width too small for register map");
   end

   logic [NUM_FIELDS-1:0][DATA_W-1:0] regs_q;
   logic [NUM_FIELDS-1:0][VAL_W-1:0]  cur_ext;
   logic [NUM_FIELDS-1:0]             f_en, f_hit;
   logic any_en, all_hit, aie_q, ctrl_wr;

   always_comb begin
      cur_ext[0] = VAL_W'(cur_min);
      cur_ext[1] = VAL_W'(cur_hour);
      cur_ext[2] = VAL_W'(cur_day);
      cur_ext[3] = VAL_W'(cur_wday);
      ctrl_wr    = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   end

   alm_regfile #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .regs_q(regs_q));

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
      alm_field_match #(.VAL_W(VAL_W)) u_match (
         .reg_q(regs_q[i]), .cur(cur_ext[i]), .en(f_en[i]), .hit(f_hit[i]));
   end

   always_comb begin
      any_en  = |f_en;
      all_hit = &(f_hit | ~f_en);
   end

   alm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(wr_data),
      .step(minute_step), .any_en(any_en), .all_hit(all_hit),
      .af_q(alarm_flag), .aie_q(aie_q));

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(A_CTRL)) begin
         rd_data[CTRL_AIE] = aie_q;
         rd_data[CTRL_AF]  = alarm_flag;
      end else if (int'(rd_addr) <= NUM_FIELDS) begin
         rd_data = regs_q[int'(rd_addr) - 1];
      end
      int_n = !((alarm_flag && aie_q) || timer_irq);
   end

   a_r7_int_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr == ADDR_W'(A_CTRL) && rd_data[CTRL_AF] && rd_data[CTRL_AIE] |-> !int_n);
   a_r7_int_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !timer_irq && !alarm_flag |-> int_n);
   a_r7_timer_low: assert property (@(posedge clk) disable iff (!rst_n)
      timer_irq |-> !int_n);
endmodule

// File: tb/alm_cmp_bench.sv
module alm_cmp_bench;
   logic       clk = 0, rst_n = 0;
   logic       wr_en = 0, minute_step = 0, timer_irq = 0;
   logic [2:0] wr_addr = 0, rd_addr = 0;
   logic [7:0] wr_data = 0, rd_data;
   logic [6:0] cur_min = 0;
   logic [5:0] cur_hour = 0, cur_day = 0;
   logic [2:0] cur_wday = 0;
   logic       int_n, alarm_flag;

   int n_chk = 0, n_bad = 0;
   logic [7:0] m_reg [1:4];
   logic m_af, m_aie;

   always #4 clk = ~clk;

   alm_cmp u_alm_cmp (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cur_min(cur_min), .cur_hour(cur_hour),
      .cur_day(cur_day), .cur_wday(cur_wday), .minute_step(minute_step),
      .timer_irq(timer_irq), .int_n(int_n), .alarm_flag(alarm_flag));

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic exp_fire(logic [6:0] mi, logic [5:0] hr, logic [5:0] dy, logic [2:0] wd);
      logic [6:0] cur [1:4];
      logic any = 0, all = 1;
      cur[1] = mi; cur[2] = {1'b0, hr}; cur[3] = {1'b0, dy}; cur[4] = {4'b0, wd};
      for (int i = 1; i <= 4; i++) begin
         if (!m_reg[i][7]) begin
            any = 1;
            if (m_reg[i][6:0] != cur[i]) all = 0;
         end
      end
      return any && all;
   endfunction

   function automatic logic exp_int();
      return !((m_af && m_aie) || timer_irq);
   endfunction

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
      if (a == 0) begin
         m_aie = d[0];
         if (!d[1]) m_af = 0;
      end else if (a <= 4) m_reg[a] = d;
   endtask

   task automatic step(logic [6:0] mi, logic [5:0] hr, logic [5:0] dy, logic [2:0] wd);
      @(negedge clk);
      cur_min = mi; cur_hour = hr; cur_day = dy; cur_wday = wd;
      minute_step = 1;
      if (exp_fire(mi, hr, dy, wd)) m_af = 1;
      @(negedge clk);
      minute_step = 0;
   endtask

   task automatic check_state(string req);
      rd_addr = 0; #1;
      check(req, {7'b0, alarm_flag}, {7'b0, m_af});
      check(req, rd_data, {6'b0, m_af, m_aie});
      check(req, {7'b0, int_n}, {7'b0, exp_int()});
   endtask

   initial begin
      logic [6:0] mins [0:2];
      logic [5:0] hrs  [0:2];
      int seed;
      mins = '{7'h00, 7'h30, 7'h59};
      hrs  = '{6'h00, 6'h12, 6'h23};
      seed = 7;
      void'($urandom(seed));
      for (int i = 1; i <= 4; i++) m_reg[i] = 8'h80;
      m_af = 0; m_aie = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check_state("R1");
      for (int a = 1; a <= 4; a++) begin
         rd_addr = 3'(a); #1;
         check("R1", rd_data, 8'h80);
      end

      // R2 register map readback
      wr(1, 8'h25); wr(3, 8'hA7);
      rd_addr = 1; #1; check("R2", rd_data, 8'h25);
      rd_addr = 3; #1; check("R2", rd_data, 8'hA7);
      wr(5, 8'h55);
      rd_addr = 5; #1; check("R2", rd_data, 8'h00);
      rd_addr = 7; #1; check("R2", rd_data, 8'h00);

      // R8 all disabled
      wr(1, 8'h80); wr(3, 8'h80);
      step(7'h00, 6'h00, 6'h00, 3'd0);
      check_state("R8");

      // R3 match with minute and hour enabled, R7 int low
      wr(1, 8'h30); wr(2, 8'h23); wr(0, 8'h01);
      step(7'h30, 6'h22, 6'h01, 3'd1);
      check_state("R3");
      step(7'h30, 6'h23, 6'h15, 3'd6);
      check_state("R3");
      check("R7", {7'b0, int_n}, 8'h00);

      // R6 write with bit1=1 keeps flag, write 0 clears
      wr(0, 8'h03);
      check_state("R6");
      wr(0, 8'h01);
      check_state("R6");

      // R5 matching time without strobe
      @(negedge clk);
      cur_min = 7'h30; cur_hour = 6'h23;
      repeat (5) @(negedge clk);
      check_state("R5");

      // R4 disabled hour ignored
      wr(2, 8'hA3);
      step(7'h30, 6'h05, 6'h09, 3'd2);
      check_state("R4");

      // R9 enable off: flag sets, line stays high
      wr(0, 8'h00);
      step(7'h30, 6'h11, 6'h09, 3'd2);
      check_state("R9");
      check("R9", {7'b0, int_n}, 8'h01);
      timer_irq = 1; #1;
      check("R7", {7'b0, int_n}, 8'h00);
      @(negedge clk); timer_irq = 0;

      // R6 clear and match on same cycle: set wins
      wr(0, 8'h00);
      @(negedge clk);
      wr_en = 1; wr_addr = 0; wr_data = 8'h01;
      cur_min = 7'h30; minute_step = 1;
      @(negedge clk);
      wr_en = 0; minute_step = 0;
      m_aie = 1; m_af = 1;
      check_state("R6");

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         op = $urandom_range(0, 9);
         if (op < 3) begin
            logic [2:0] a;
            logic [7:0] d;
            a = 3'($urandom_range(1, 4));
            case (a)
               1: d = {1'b0, mins[$urandom_range(0, 2)]};
               2: d = {2'b0, hrs[$urandom_range(0, 2)]};
               3: d = 8'($urandom_range(1, 2));
               default: d = 8'($urandom_range(0, 1));
            endcase
            d[7] = ($urandom_range(0, 2) == 0);
            wr(a, d);
         end else if (op == 3) begin
            wr(0, 8'($urandom_range(0, 3)));
         end else if (op == 4) begin
            timer_irq = $urandom_range(0, 1) == 1;
            #1;
         end else begin
            step(mins[$urandom_range(0, 2)], hrs[$urandom_range(0, 2)],
                 6'($urandom_range(1, 2)), 3'($urandom_range(0, 1)));
         end
         check_state("R3");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule